// File: doc/BRIEF.md
# Preemptive DMA Channel Priority Arbiter

This block decides which of 32 DMA channels the transfer engine serves next, and whether a waiting channel may cut into the transfer that is running. Every channel owns one priority byte on a small byte-wide register bus. The byte holds a 4-bit channel priority that software can write, a 2-bit group priority that is fixed, and two flags. The first flag lets the channel be suspended. The second flag stops the channel from suspending anyone else.

When the engine is idle, the arbiter grants the pending request with the highest group and channel priority. When the engine is busy, a pending request that outranks the active channel can trigger a preemption. This happens only if the active channel allows suspension, the requester has not been barred from preempting, and the single suspend slot is free. The arbiter records which channel was suspended. When the preempting transfer reports completion, it grants that channel again ahead of any new arbitration.

Together, the two flags let software build a pool of low-priority bulk channels that never preempt one another. The one suspend slot then stays free for genuinely urgent traffic.

Top module: `dma_prio_arbiter`

## Requirements
- R1: Channel n's priority byte sits at bus address 0x100+n. Its layout is bit 7 = suspend-allowed flag, bit 6 = no-preempt flag, bits 5:4 = group priority and bits 3:0 = channel priority. A read strobe returns the byte on `reg_rdata` at the clock edge that samples the strobe.
- R2: After reset, both flags are 0 in every channel. The channel priority equals n mod 16 and the group priority equals n div 16. `grant_valid`, `preempt_req` and `susp_valid` are 0.
- R3: Writes never change the group priority bits 5:4. Bits 7, 6 and 3:0 take the written value.
- R4: With `eng_busy` low and at least one request pending, `grant_valid` is 1 in the following cycle. `grant_ch` then names the pending channel with the highest group priority, and among those the highest channel priority. With no request pending, `grant_valid` is 0.
- R5: When pending channels have equal group and channel priority, the lowest channel index wins.
- R6: With `eng_busy` high, `preempt_req` pulses for one cycle when all four conditions hold: the best pending channel outranks `eng_ch` on {group, channel} priority; `eng_ch` has its suspend-allowed flag set; the best pending channel has its no-preempt flag clear; and no channel is suspended. In that cycle `grant_ch` names the preempting channel, `susp_ch` names the previous `eng_ch`, and `susp_valid` rises.
- R7: No preemption occurs while the active channel's suspend-allowed flag is 0.
- R8: No preemption occurs when the best pending channel's no-preempt flag is 1, whatever the priorities.
- R9: No preemption occurs when the best pending channel ranks equal to or below the active channel.
- R10: While `susp_valid` is 1, no further preemption is raised and `susp_ch` holds its value.
- R11: When `eng_done` is high while `susp_valid` is 1, the next cycle shows `grant_valid` = 1 with `grant_ch` = the suspended channel, even if other requests are pending. `susp_valid` returns to 0.
- R12: Accesses outside 0x100..0x11F change no channel byte, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 9 | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| req | input | 32 | Per-channel service requests |
| eng_busy | input | 1 | Engine is serving a channel |
| eng_ch | input | 5 | Index of the channel being served |
| eng_done | input | 1 | Active (preempting) transfer has completed |
| grant_valid | output | 1 | Grant to an idle engine or resume of the suspended channel |
| grant_ch | output | 5 | Granted or preempting channel index |
| preempt_req | output | 1 | One-cycle request to suspend the active channel |
| susp_valid | output | 1 | Suspend slot is occupied |
| susp_ch | output | 5 | Index of the suspended channel |

## Verification
The bench sweeps every ordered pair of active and requesting channels with flag patterns that cover all four flag combinations. It checks that a design which ignored either flag, or compared priorities with the wrong strictness, would raise `preempt_req` where it must not (or stay silent where it must fire). Group priority dominance across the two halves and the tie rule that favours the lower index are probed after reprogramming the priorities. This exposes a design that ranks by index alone or scans in the wrong direction. Further targets are a second preemption attempted while the slot is full, which a design without the slot check would accept, and a resume that must beat a pending higher-priority request. Writes to the read-only group field and to out-of-window addresses are read back to catch a register that accepts them.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int GRP_W = 2;
  localparam int PRI_W = 4;
  localparam int KEY_W = GRP_W + PRI_W;

  // Byte layout: [7]=suspend allowed, [6]=no-preempt, [5:4]=group, [3:0]=priority
  typedef struct packed {
    logic             susp_ok;
    logic             no_preempt;
    logic [GRP_W-1:0] grp;
    logic [PRI_W-1:0] pri;
  } ch_cfg_t;
endpackage

// File: rtl/arb_prio_regs.sv
module arb_prio_regs
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int GRP_SIZE = 16,
  parameter int ADDR_W   = 9,
  parameter int BASE     = 256
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic                       re,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [7:0]                 wdata,
  output logic [7:0]                 rdata,
  output ch_cfg_t [NUM_CH-1:0]       cfg
);
  localparam int CH_W = $clog2(NUM_CH);

  logic            hit;
  logic [CH_W-1:0] idx;
  logic [ADDR_W-1:0] offs;

  assign offs = addr - ADDR_W'(BASE);
  assign hit  = (addr >= ADDR_W'(BASE)) && (addr < ADDR_W'(BASE + NUM_CH));
  assign idx  = offs[CH_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ch_cfg_t r;
    always_ff @(posedge clk) begin
      if (rst) begin
        r.susp_ok    <= 1'b0;
        r.no_preempt <= 1'b0;
        r.grp        <= GRP_W'(g / GRP_SIZE);
        r.pri        <= PRI_W'(g % GRP_SIZE);
      end else if (we && hit && idx == CH_W'(g)) begin
        r.susp_ok    <= wdata[7];
        r.no_preempt <= wdata[6];
        r.pri        <= wdata[PRI_W-1:0];
      end
    end
    assign cfg[g] = r;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= hit ? cfg[idx] : 8'h00;
  end
endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  ch_cfg_t [NUM_CH-1:0]       cfg,
  input  logic [NUM_CH-1:0]          req,
  output logic                       any,
  output logic [$clog2(NUM_CH)-1:0]  win_ch,
  output logic [KEY_W-1:0]           win_key
);
  localparam int CH_W = $clog2(NUM_CH);

  // Downward scan with >= lets the lower index replace an equal key.
  always_comb begin
    any     = 1'b0;
    win_ch  = '0;
    win_key = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i] && (!any || {cfg[i].grp, cfg[i].pri} >= win_key)) begin
        any     = 1'b1;
        win_ch  = CH_W'(i);
        win_key = {cfg[i].grp, cfg[i].pri};
      end
    end
  end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int GRP_SIZE = 16,
  parameter int ADDR_W   = 9,
  parameter int BASE     = 256,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [NUM_CH-1:0] req,
  input  logic              eng_busy,
  input  logic [CH_W-1:0]   eng_ch,
  input  logic              eng_done,
  output logic              grant_valid,
  output logic [CH_W-1:0]   grant_ch,
  output logic              preempt_req,
  output logic              susp_valid,
  output logic [CH_W-1:0]   susp_ch
);
  ch_cfg_t [NUM_CH-1:0] cfg;
  logic                 any;
  logic [CH_W-1:0]      win_ch;
  logic [KEY_W-1:0]     win_key;
  logic [KEY_W-1:0]     act_key;
  logic                 may_preempt;

  arb_prio_regs #(
    .NUM_CH(NUM_CH), .GRP_SIZE(GRP_SIZE), .ADDR_W(ADDR_W), .BASE(BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .re(reg_re), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg)
  );

  arb_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
    .cfg(cfg), .req(req), .any(any), .win_ch(win_ch), .win_key(win_key)
  );

  assign act_key     = {cfg[eng_ch].grp, cfg[eng_ch].pri};
  assign may_preempt = eng_busy && any && !susp_valid
                       && (win_key > act_key)
                       && cfg[eng_ch].susp_ok
                       && !cfg[win_ch].no_preempt;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_ch    <= '0;
      preempt_req <= 1'b0;
      susp_valid  <= 1'b0;
      susp_ch     <= '0;
    end else begin
      grant_valid <= 1'b0;
      preempt_req <= 1'b0;
      if (susp_valid && eng_done) begin
        grant_valid <= 1'b1;
        grant_ch    <= susp_ch;
        susp_valid  <= 1'b0;
      end else if (!eng_busy && any) begin
        grant_valid <= 1'b1;
        grant_ch    <= win_ch;
      end else if (may_preempt) begin
        preempt_req <= 1'b1;
        grant_ch    <= win_ch;
        susp_valid  <= 1'b1;
        susp_ch     <= eng_ch;
      end
    end
  end
endmodule

// File: rtl/dma_prio_arbiter_chk.sv
module dma_prio_arbiter_chk #(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 9,
  parameter int BASE   = 256,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_re,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_rdata,
  input logic              eng_busy,
  input logic              eng_done,
  input logic              grant_valid,
  input logic [CH_W-1:0]   grant_ch,
  input logic              preempt_req,
  input logic              susp_valid,
  input logic [CH_W-1:0]   susp_ch
);
  logic outside;
  assign outside = (int'(reg_addr) < BASE) || (int'(reg_addr) >= BASE + NUM_CH);

  p_excl_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({grant_valid, preempt_req}));
  p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    preempt_req |=> !preempt_req);
  p_busy_r6: assert property (@(posedge clk) disable iff (rst)
    preempt_req |-> $past(eng_busy));
  p_slot_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(susp_valid) |-> preempt_req);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (susp_valid && !eng_done) |=> (susp_valid && $stable(susp_ch)));
  p_resume_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(susp_valid) |-> (grant_valid && grant_ch == $past(susp_ch)));
  p_rdzero_r12: assert property (@(posedge clk) disable iff (rst)
    (reg_re && outside) |=> (reg_rdata == 8'h00));
endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BASE(BASE)
) u_chk (
  .clk(clk), .rst(rst), .reg_re(reg_re), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .eng_busy(eng_busy), .eng_done(eng_done),
  .grant_valid(grant_valid), .grant_ch(grant_ch), .preempt_req(preempt_req),
  .susp_valid(susp_valid), .susp_ch(susp_ch)
);

// File: tb/dma_prio_arbiter_tb.sv
module dma_prio_arbiter_tb;
  localparam int N = 32;

  logic        clk = 0;
  logic        rst = 1;
  logic        reg_we = 0, reg_re = 0;
  logic [8:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic [N-1:0] req = 0;
  logic        eng_busy = 0, eng_done = 0;
  logic [4:0]  eng_ch = 0;
  logic        grant_valid, preempt_req, susp_valid;
  logic [4:0]  grant_ch, susp_ch;

  int errors = 0, checks = 0;
  logic       m_ok [N];
  logic       m_np [N];
  logic [3:0] m_pri [N];

  always #5 clk = ~clk;

  dma_prio_arbiter u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req(req), .eng_busy(eng_busy),
    .eng_ch(eng_ch), .eng_done(eng_done), .grant_valid(grant_valid),
    .grant_ch(grant_ch), .preempt_req(preempt_req), .susp_valid(susp_valid),
    .susp_ch(susp_ch)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int key(input int n);
    return (n / 16) * 16 + int'(m_pri[n]);
  endfunction

  function automatic int best(input logic [N-1:0] v);
    int b = -1;
    for (int i = 0; i < N; i++)
      if (v[i] && (b < 0 || key(i) > key(b))) b = i;
    return b;
  endfunction

  task automatic wr(input int ch, input logic [7:0] d);
    reg_we = 1; reg_addr = 9'(256 + ch); reg_wdata = d;
    tick();
    reg_we = 0;
    if (ch >= 0 && ch < N) begin
      m_ok[ch] = d[7]; m_np[ch] = d[6]; m_pri[ch] = d[3:0];
    end
  endtask

  task automatic rd_addr(input int a, output logic [7:0] d);
    reg_re = 1; reg_addr = 9'(a);
    tick();
    reg_re = 0;
    d = reg_rdata;
  endtask

  function automatic logic [7:0] exp_byte(input int n);
    return {m_ok[n], m_np[n], 2'(n / 16), m_pri[n]};
  endfunction

  task automatic idle_sweep(input string tag, input int count, input logic [31:0] seed);
    logic [31:0] s = seed;
    for (int k = 0; k < count; k++) begin
      int e;
      s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
      req = (k % 3 == 0) ? (s & {s[15:0], s[31:16]}) : s;
      if (k == 0) req = '0;
      eng_busy = 0;
      tick();
      e = best(req);
      chk(grant_valid == (e >= 0), {tag, " grant_valid"}, int'(grant_valid), int'(e >= 0));
      if (e >= 0) chk(grant_ch == 5'(e), {tag, " grant_ch"}, int'(grant_ch), e);
    end
    req = '0;
  endtask

  initial begin
    logic [7:0] d;
    for (int i = 0; i < N; i++) begin
      m_ok[i] = 0; m_np[i] = 0; m_pri[i] = 4'(i % 16);
    end
    tick(); tick();
    rst = 0;
    chk(!grant_valid && !preempt_req && !susp_valid, "R2 outputs after reset",
        int'({grant_valid, preempt_req, susp_valid}), 0);

    // R2/R1: reset contents of every byte
    for (int i = 0; i < N; i++) begin
      rd_addr(256 + i, d);
      chk(d == exp_byte(i), "R2 reset byte", int'(d), int'(exp_byte(i)));
    end

    // R1/R3: write with group bits set to the inverse, read back
    for (int i = 0; i < N; i++) begin
      logic [7:0] w = 8'(i * 37 + 11) ^ 8'h30;
      wr(i, w);
      rd_addr(256 + i, d);
      chk(d == exp_byte(i), "R3 group read-only / R1 layout", int'(d), int'(exp_byte(i)));
    end

    // R12: out-of-window accesses
    wr(-1, 8'hFF);
    wr(32, 8'hFF);
    reg_we = 1; reg_addr = 9'h010; reg_wdata = 8'hFF; tick(); reg_we = 0;
    for (int i = 0; i < N; i += 31) begin
      rd_addr(256 + i, d);
      chk(d == exp_byte(i), "R12 no side effect", int'(d), int'(exp_byte(i)));
    end
    rd_addr(9'h0FF, d);
    chk(d == 8'h00, "R12 read below window", int'(d), 0);
    rd_addr(9'h120, d);
    chk(d == 8'h00, "R12 read above window", int'(d), 0);

    // R4: reset-style priorities, then a permuted set
    for (int i = 0; i < N; i++) wr(i, 8'(i % 16));
    idle_sweep("R4 sweep A", 150, 32'h1234_5679);
    for (int i = 0; i < N; i++) wr(i, 8'((i * 7 + 3) % 16));
    idle_sweep("R4 sweep B", 150, 32'hCAFE_0001);
    for (int i = 0; i < N; i++) begin
      req = N'(1) << i; tick();
      chk(grant_valid && grant_ch == 5'(i), "R4 single request", int'(grant_ch), i);
    end
    req = '0;

    // R5: ties resolve to the lower index
    wr(3, 8'h09); wr(5, 8'h09); wr(12, 8'h09);
    req = (N'(1) << 5) | (N'(1) << 12) | (N'(1) << 3); tick();
    chk(grant_valid && grant_ch == 5'd3, "R5 tie lower index", int'(grant_ch), 3);
    wr(20, 8'h02); wr(17, 8'h02);
    req = (N'(1) << 20) | (N'(1) << 17); tick();
    chk(grant_valid && grant_ch == 5'd17, "R5 tie upper group", int'(grant_ch), 17);
    req = '0;

    // R6-R9: every ordered pair, flags from index bits
    for (int i = 0; i < N; i++) wr(i, {i[0], i[1], 2'b00, 4'(i % 16)});
    for (int a = 0; a < N; a++) begin
      for (int r = 0; r < N; r++) begin
        bit e;
        if (r == a) continue;
        e = (key(r) > key(a)) && m_ok[a] && !m_np[r];
        eng_busy = 1; eng_ch = 5'(a); req = N'(1) << r; eng_done = 0;
        tick();
        chk(preempt_req == e, "R6 R7 R8 R9 preempt decision", int'(preempt_req), int'(e));
        if (e) begin
          chk(grant_ch == 5'(r) && susp_valid && susp_ch == 5'(a),
              "R6 preempt ids", int'(susp_ch), a);
          req = '0; eng_ch = 5'(r); eng_done = 1;
          tick();
          chk(grant_valid && grant_ch == 5'(a) && !susp_valid,
              "R11 resume", int'(grant_ch), a);
          eng_done = 0;
        end
      end
    end

    // R10 and R11: full slot blocks a second preemption; resume beats a pending request
    eng_busy = 1; eng_ch = 5'd1; req = N'(1) << 9; tick();
    chk(preempt_req && susp_ch == 5'd1, "R6 first preempt", int'(preempt_req), 1);
    eng_ch = 5'd9; req = N'(1) << 29; tick();
    chk(!preempt_req && susp_valid && susp_ch == 5'd1, "R10 slot full", int'(preempt_req), 0);
    tick();
    chk(!preempt_req && susp_ch == 5'd1, "R10 hold", int'(susp_ch), 1);
    eng_done = 1; tick();
    chk(grant_valid && grant_ch == 5'd1 && !susp_valid, "R11 resume ahead of request",
        int'(grant_ch), 1);
    eng_done = 0; eng_busy = 0; req = '0; tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule